// File: doc/BRIEF.md
# Shared-Bus Datapath Core

This block is the data side of a microcoded processor in which every transfer crosses one 32-bit common bus. In each cycle a microcode sequencer (outside this block) raises at most one of four drive enables to pick the bus source. The sources are:

- an immediate extender fed from the instruction register;
- a combinational ALU working on the two operand registers;
- a read value supplied by an external register file;
- a read value supplied by an external memory.

The same control word also raises any set of four load strobes. The instruction register, the two operand registers and the memory address register all capture the bus at the next rising clock edge.

The sequencer steers microcode from the instruction fields the block brings out: opcode, function code and the three register specifiers. It also uses the ALU zero flag for conditional microbranches. The memory address register feeds the external memory address. The bus itself is brought out so it can serve as write data for the register file and memory. All pins are plain control and data levels with no handshake, because every transfer completes within the cycle in which it is commanded.

Top module: `shared_bus_datapath`

## Requirements
- R1: With exactly one drive enable high, `bus_out` equals that source: `drv_imm` selects the extended immediate, `drv_alu` the ALU result, `drv_rf` `rf_rdata`, and `drv_mem` `mem_rdata`.
- R2: With no drive enable high, `bus_out` is all ones.
- R3: `bus_conflict` is high in exactly the cycles where two or more drive enables are high. The bus value in such a cycle is unspecified.
- R4: Each of the instruction, A, B and address registers takes the `bus_out` value at a rising edge when its load strobe is high, and keeps its value when the strobe is low.
- R5: When several load strobes are high together, every selected register captures the same bus value.
- R6: `rst` high at a rising edge clears all four registers to zero. Reset takes priority over loads.
- R7: `ext_mode` selects the immediate form, using the low 16 bits IR[15:0] or the low 26 bits IR[25:0]: 0 zero-extends 16 bits, 1 zero-extends 26 bits, 2 sign-extends 16 bits from bit 15, and 3 sign-extends 26 bits from bit 25.
- R8: `alu_op` encodes 0 copy A, 1 copy B, 2 A+1, 3 A-1, 4 A+4, 5 A-4, 6 A+B and 7 A-B. All arithmetic wraps modulo 2^32.
- R9: `alu_zero` is 1 exactly when the ALU result for the current `alu_op` is zero, whether or not the ALU drives the bus.
- R10: The instruction fields are taken from the instruction register: `opcode` = IR[31:26], `rs_field` = IR[25:21], `rt_field` = IR[20:16], `rd_field` = IR[15:11] and `funct` = IR[5:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| drv_imm | input | 1 | Extended immediate drives the bus |
| drv_alu | input | 1 | ALU result drives the bus |
| drv_rf | input | 1 | Register file read value drives the bus |
| drv_mem | input | 1 | Memory read value drives the bus |
| ld_ir | input | 1 | Instruction register loads from the bus |
| ld_a | input | 1 | Operand A loads from the bus |
| ld_b | input | 1 | Operand B loads from the bus |
| ld_ma | input | 1 | Address register loads from the bus |
| ext_mode | input | 2 | Immediate extension mode |
| alu_op | input | 3 | ALU operation |
| rf_rdata | input | 32 | Register file read value |
| mem_rdata | input | 32 | Memory read value |
| bus_out | output | 32 | Current bus value |
| bus_conflict | output | 1 | Two or more drive enables high |
| opcode | output | 6 | Opcode field of the instruction register |
| funct | output | 6 | Function field of the instruction register |
| rs_field | output | 5 | First source register specifier |
| rt_field | output | 5 | Second source register specifier |
| rd_field | output | 5 | Destination register specifier |
| alu_zero | output | 1 | ALU result is zero |
| mem_addr | output | 32 | Address register contents |

## Verification
The assertions check on every cycle:

- register-file, memory and idle routing onto the bus;
- agreement of the conflict flag with the enable count;
- capture and hold of the address register;
- equal capture when the instruction and address registers load together;
- clearing on reset;
- agreement of the zero flag with the bus whenever the ALU drives it alone.

The bench's scenarios have to cover what a property cannot see in one relation: every ALU operation and extender mode at its wrap and sign boundaries, the A and B contents brought out through copy operations, and the instruction field split.

// File: rtl/bus_dp_pkg.sv
package bus_dp_pkg;

  typedef enum logic [1:0] {
    EXT_ZERO_SHORT = 2'd0,
    EXT_ZERO_LONG  = 2'd1,
    EXT_SIGN_SHORT = 2'd2,
    EXT_SIGN_LONG  = 2'd3
  } ext_mode_e;

  typedef enum logic [2:0] {
    ALU_PASS_A = 3'd0,
    ALU_PASS_B = 3'd1,
    ALU_INC1   = 3'd2,
    ALU_DEC1   = 3'd3,
    ALU_INC4   = 3'd4,
    ALU_DEC4   = 3'd5,
    ALU_ADD    = 3'd6,
    ALU_SUB    = 3'd7
  } alu_op_e;

  // Bus source slots
  localparam int SRC_IMM = 0;
  localparam int SRC_ALU = 1;
  localparam int SRC_RF  = 2;
  localparam int SRC_MEM = 3;
  localparam int NUM_SRC = 4;

  // Bus destination slots
  localparam int DST_IR  = 0;
  localparam int DST_A   = 1;
  localparam int DST_B   = 2;
  localparam int DST_MA  = 3;
  localparam int NUM_DST = 4;

endpackage

// File: rtl/bdp_imm_ext.sv
module bdp_imm_ext
  import bus_dp_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SHORT_W = 16,
  parameter int LONG_W  = 26
) (
  input  logic [DATA_W-1:0] ir_word,
  input  ext_mode_e         mode,
  output logic [DATA_W-1:0] imm_val
);
  localparam int PAD_SHORT = DATA_W - SHORT_W;
  localparam int PAD_LONG  = DATA_W - LONG_W;

  logic [SHORT_W-1:0] short_f;
  logic [LONG_W-1:0]  long_f;
  logic               short_msb;
  logic               long_msb;

  assign short_f   = ir_word[SHORT_W-1:0];
  assign long_f    = ir_word[LONG_W-1:0];
  assign short_msb = short_f[SHORT_W-1];
  assign long_msb  = long_f[LONG_W-1];

  always_comb begin
    unique case (mode)
      EXT_ZERO_SHORT: imm_val = {{PAD_SHORT{1'b0}}, short_f};
      EXT_ZERO_LONG:  imm_val = {{PAD_LONG{1'b0}}, long_f};
      EXT_SIGN_SHORT: imm_val = {{PAD_SHORT{short_msb}}, short_f};
      EXT_SIGN_LONG:  imm_val = {{PAD_LONG{long_msb}}, long_f};
      default:        imm_val = '0;
    endcase
  end
endmodule

// File: rtl/bdp_alu.sv
module bdp_alu
  import bus_dp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  alu_op_e           op,
  output logic [DATA_W-1:0] result,
  output logic              is_zero
);
  localparam logic [DATA_W-1:0] ONE  = DATA_W'(1);
  localparam logic [DATA_W-1:0] FOUR = DATA_W'(4);

  always_comb begin
    unique case (op)
      ALU_PASS_A: result = opa;
      ALU_PASS_B: result = opb;
      ALU_INC1:   result = opa + ONE;
      ALU_DEC1:   result = opa - ONE;
      ALU_INC4:   result = opa + FOUR;
      ALU_DEC4:   result = opa - FOUR;
      ALU_ADD:    result = opa + opb;
      ALU_SUB:    result = opa - opb;
      default:    result = '0;
    endcase
  end

  assign is_zero = ~|result;
endmodule

// File: rtl/bdp_bus_sel.sv
module bdp_bus_sel #(
  parameter int DATA_W = 32,
  parameter int NSRC   = 4
) (
  input  logic [NSRC-1:0][DATA_W-1:0] src,
  input  logic [NSRC-1:0]             en,
  output logic [DATA_W-1:0]           bus,
  output logic                        conflict
);
  localparam int CNT_W = $clog2(NSRC + 1);

  logic [DATA_W-1:0] or_tree;
  logic [CNT_W-1:0]  n_on;

  always_comb begin
    or_tree = '0;
    n_on    = '0;
    for (int i = 0; i < NSRC; i++) begin
      or_tree = or_tree | (src[i] & {DATA_W{en[i]}});
      n_on    = n_on + CNT_W'(en[i]);
    end
  end

  assign bus      = (|en) ? or_tree : '1;
  assign conflict = (n_on > CNT_W'(1));
endmodule

// File: rtl/bdp_load_reg.sv
module bdp_load_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/shared_bus_datapath.sv
module shared_bus_datapath
  import bus_dp_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SHORT_W = 16,
  parameter int LONG_W  = 26
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              drv_imm,
  input  logic              drv_alu,
  input  logic              drv_rf,
  input  logic              drv_mem,
  input  logic              ld_ir,
  input  logic              ld_a,
  input  logic              ld_b,
  input  logic              ld_ma,
  input  logic [1:0]        ext_mode,
  input  logic [2:0]        alu_op,
  input  logic [DATA_W-1:0] rf_rdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_conflict,
  output logic [5:0]        opcode,
  output logic [5:0]        funct,
  output logic [4:0]        rs_field,
  output logic [4:0]        rt_field,
  output logic [4:0]        rd_field,
  output logic              alu_zero,
  output logic [DATA_W-1:0] mem_addr
);
  localparam int SPEC_W = 5;
  localparam int OP_W   = 6;
  localparam int OP_LO  = DATA_W - OP_W;
  localparam int RS_LO  = OP_LO - SPEC_W;
  localparam int RT_LO  = RS_LO - SPEC_W;
  localparam int RD_LO  = RT_LO - SPEC_W;

  logic [NUM_SRC-1:0][DATA_W-1:0] src_vec;
  logic [NUM_SRC-1:0]             drv_vec;
  logic [NUM_DST-1:0]             ld_vec;
  logic [NUM_DST-1:0][DATA_W-1:0] reg_q;

  logic [DATA_W-1:0] ir_q;
  logic [DATA_W-1:0] a_q;
  logic [DATA_W-1:0] b_q;
  logic [DATA_W-1:0] imm_val;
  logic [DATA_W-1:0] alu_res;

  assign drv_vec[SRC_IMM] = drv_imm;
  assign drv_vec[SRC_ALU] = drv_alu;
  assign drv_vec[SRC_RF]  = drv_rf;
  assign drv_vec[SRC_MEM] = drv_mem;

  assign src_vec[SRC_IMM] = imm_val;
  assign src_vec[SRC_ALU] = alu_res;
  assign src_vec[SRC_RF]  = rf_rdata;
  assign src_vec[SRC_MEM] = mem_rdata;

  assign ld_vec[DST_IR] = ld_ir;
  assign ld_vec[DST_A]  = ld_a;
  assign ld_vec[DST_B]  = ld_b;
  assign ld_vec[DST_MA] = ld_ma;

  bdp_bus_sel #(.DATA_W(DATA_W), .NSRC(NUM_SRC)) u_bus (
    .src      (src_vec),
    .en       (drv_vec),
    .bus      (bus_out),
    .conflict (bus_conflict)
  );

  for (genvar g = 0; g < NUM_DST; g++) begin : g_dst
    bdp_load_reg #(.DATA_W(DATA_W)) u_reg (
      .clk  (clk),
      .rst  (rst),
      .load (ld_vec[g]),
      .d    (bus_out),
      .q    (reg_q[g])
    );
  end

  assign ir_q     = reg_q[DST_IR];
  assign a_q      = reg_q[DST_A];
  assign b_q      = reg_q[DST_B];
  assign mem_addr = reg_q[DST_MA];

  bdp_imm_ext #(.DATA_W(DATA_W), .SHORT_W(SHORT_W), .LONG_W(LONG_W)) u_ext (
    .ir_word (ir_q),
    .mode    (ext_mode_e'(ext_mode)),
    .imm_val (imm_val)
  );

  bdp_alu #(.DATA_W(DATA_W)) u_alu (
    .opa     (a_q),
    .opb     (b_q),
    .op      (alu_op_e'(alu_op)),
    .result  (alu_res),
    .is_zero (alu_zero)
  );

  assign opcode   = ir_q[DATA_W-1:OP_LO];
  assign rs_field = ir_q[OP_LO-1:RS_LO];
  assign rt_field = ir_q[RS_LO-1:RT_LO];
  assign rd_field = ir_q[RT_LO-1:RD_LO];
  assign funct    = ir_q[OP_W-1:0];
endmodule

// File: rtl/shared_bus_datapath_chk.sv
module shared_bus_datapath_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              drv_imm,
  input logic              drv_alu,
  input logic              drv_rf,
  input logic              drv_mem,
  input logic              ld_ir,
  input logic              ld_ma,
  input logic [DATA_W-1:0] rf_rdata,
  input logic [DATA_W-1:0] mem_rdata,
  input logic [DATA_W-1:0] bus_out,
  input logic              bus_conflict,
  input logic              alu_zero,
  input logic [DATA_W-1:0] mem_addr,
  input logic [DATA_W-1:0] ir_q
);
  logic [3:0] drv;
  assign drv = {drv_mem, drv_rf, drv_alu, drv_imm};

  // R1
  rf_route_chk: assert property (@(posedge clk) disable iff (rst)
    (drv == 4'b0100) |-> (bus_out == rf_rdata));

  // R1
  mem_route_chk: assert property (@(posedge clk) disable iff (rst)
    (drv == 4'b1000) |-> (bus_out == mem_rdata));

  // R2
  idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
    (drv == 4'b0000) |-> (bus_out == '1));

  // R3
  conflict_flag_chk: assert property (@(posedge clk) disable iff (rst)
    !$onehot0(drv) |-> bus_conflict);

  // R3
  no_conflict_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(drv) |-> !bus_conflict);

  // R4
  ma_load_chk: assert property (@(posedge clk) disable iff (rst)
    ld_ma |=> (mem_addr == $past(bus_out)));

  // R4
  ma_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ld_ma |=> $stable(mem_addr));

  // R5
  same_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_ir && ld_ma) |=> (ir_q == mem_addr));

  // R6
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (mem_addr == '0 && ir_q == '0));

  // R9
  zero_on_bus_chk: assert property (@(posedge clk) disable iff (rst)
    (drv == 4'b0010) |-> (alu_zero == (bus_out == '0)));
endmodule

bind shared_bus_datapath shared_bus_datapath_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .drv_imm      (drv_imm),
  .drv_alu      (drv_alu),
  .drv_rf       (drv_rf),
  .drv_mem      (drv_mem),
  .ld_ir        (ld_ir),
  .ld_ma        (ld_ma),
  .rf_rdata     (rf_rdata),
  .mem_rdata    (mem_rdata),
  .bus_out      (bus_out),
  .bus_conflict (bus_conflict),
  .alu_zero     (alu_zero),
  .mem_addr     (mem_addr),
  .ir_q         (ir_q)
);

// File: tb/shared_bus_datapath_test.sv
module shared_bus_datapath_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        drv_imm = 0, drv_alu = 0, drv_rf = 0, drv_mem = 0;
  logic        ld_ir = 0, ld_a = 0, ld_b = 0, ld_ma = 0;
  logic [1:0]  ext_mode = 0;
  logic [2:0]  alu_op = 0;
  logic [31:0] rf_rdata = 0, mem_rdata = 0;
  logic [31:0] bus_out;
  logic        bus_conflict;
  logic [5:0]  opcode, funct;
  logic [4:0]  rs_field, rt_field, rd_field;
  logic        alu_zero;
  logic [31:0] mem_addr;

  int checks = 0;
  int errors = 0;
  bit checking = 0;
  bit done = 0;

  // Reference state
  logic [31:0] m_ir = 0, m_a = 0, m_b = 0, m_ma = 0;

  always #10 clk = ~clk;

  shared_bus_datapath uut (
    .clk(clk), .rst(rst),
    .drv_imm(drv_imm), .drv_alu(drv_alu), .drv_rf(drv_rf), .drv_mem(drv_mem),
    .ld_ir(ld_ir), .ld_a(ld_a), .ld_b(ld_b), .ld_ma(ld_ma),
    .ext_mode(ext_mode), .alu_op(alu_op),
    .rf_rdata(rf_rdata), .mem_rdata(mem_rdata),
    .bus_out(bus_out), .bus_conflict(bus_conflict),
    .opcode(opcode), .funct(funct),
    .rs_field(rs_field), .rt_field(rt_field), .rd_field(rd_field),
    .alu_zero(alu_zero), .mem_addr(mem_addr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_imm(input logic [31:0] ir, input int mode);
    logic [31:0] v;
    if (mode == 0 || mode == 2) v = 32'(ir % 32'h1_0000);
    else                        v = 32'(ir % 32'h400_0000);
    if (mode == 2 && v >= 32'h8000)    v = v - 32'h1_0000;
    if (mode == 3 && v >= 32'h200_0000) v = v - 32'h400_0000;
    return v;
  endfunction

  function automatic logic [31:0] ref_alu(input logic [31:0] a, input logic [31:0] b, input int op);
    case (op)
      0: return a;
      1: return b;
      2: return a + 32'd1;
      3: return a - 32'd1;
      4: return a + 32'd4;
      5: return a - 32'd4;
      6: return a + b;
      default: return a - b;
    endcase
  endfunction

  // en = {mem, rf, alu, imm}; ld = {ma, b, a, ir}
  task automatic step(input string req, input bit r, input logic [3:0] en,
                      input logic [3:0] ld, input int mode, input int op,
                      input logic [31:0] rfv, input logic [31:0] memv);
    logic [31:0] eb, ea;
    int n;
    @(negedge clk);
    rst = r;
    {drv_mem, drv_rf, drv_alu, drv_imm} = en;
    {ld_ma, ld_b, ld_a, ld_ir} = ld;
    ext_mode = 2'(mode);
    alu_op = 3'(op);
    rf_rdata = rfv;
    mem_rdata = memv;
    #5;
    ea = ref_alu(m_a, m_b, op);
    n = 0;
    for (int i = 0; i < 4; i++) if (en[i]) n++;
    if (n == 0) eb = 32'hFFFF_FFFF;
    else if (en[0]) eb = ref_imm(m_ir, mode);
    else if (en[1]) eb = ea;
    else if (en[2]) eb = rfv;
    else eb = memv;
    if (checking) begin
      if (n <= 1) chk({req, " bus"}, bus_out, eb);
      chk("R3 conflict", 32'(bus_conflict), 32'(n > 1));
      chk("R9 zero", 32'(alu_zero), 32'(ea == 0));
      chk("R4 ma", mem_addr, m_ma);
      chk("R10 fields", {opcode, rs_field, rt_field, rd_field, funct},
          {m_ir[31:11], m_ir[5:0]});
    end
    @(posedge clk);
    if (r) begin
      m_ir = 0; m_a = 0; m_b = 0; m_ma = 0;
    end else begin
      if (ld[0]) m_ir = eb;
      if (ld[1]) m_a = eb;
      if (ld[2]) m_b = eb;
      if (ld[3]) m_ma = eb;
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step("R6", 1, 4'b0000, 4'b0000, 0, 0, 0, 0);
    checking = 1;
    // R6 reset state, then reset overrides load
    step("R6", 0, 4'b0100, 4'b1111, 0, 0, 32'hDEAD_BEEF, 0);
    step("R5", 0, 4'b0000, 4'b0000, 0, 0, 0, 0);
    step("R6", 1, 4'b0100, 4'b1111, 0, 0, 32'h1234_5678, 0);
    step("R6", 0, 4'b0000, 4'b0000, 0, 0, 0, 0);
    // R10 IR from memory; R1 memory route
    step("R1", 0, 4'b1000, 4'b0001, 0, 0, 0, 32'b100011_10101_01010_11001_00110_101101);
    step("R10", 0, 4'b0000, 4'b0000, 0, 0, 0, 0);
    // R7 extender with positive fields
    step("R7", 0, 4'b1000, 4'b0001, 0, 0, 0, 32'h0155_7ABC);
    for (int m = 0; m < 4; m++) step("R7", 0, 4'b0001, 4'b0000, m, 0, 0, 0);
    // R7 extender with negative fields (bit 15 and bit 25 set)
    step("R7", 0, 4'b1000, 4'b0001, 0, 0, 0, 32'hFE00_8001);
    for (int m = 0; m < 4; m++) step("R7", 0, 4'b0001, 4'b0000, m, 0, 0, 0);
    // R7 bit 15 set, bit 25 clear
    step("R7", 0, 4'b1000, 4'b0001, 0, 0, 0, 32'h01FF_F000);
    for (int m = 0; m < 4; m++) step("R7", 0, 4'b0001, 4'b0000, m, 0, 0, 0);
    // R5 A and B together, then R8 all ops
    step("R5", 0, 4'b0100, 4'b0110, 0, 0, 32'h0000_1000, 0);
    step("R5", 0, 4'b0100, 4'b0100, 0, 0, 32'h8000_0003, 0);
    for (int o = 0; o < 8; o++) step("R8", 0, 4'b0010, 4'b0000, 0, o, 0, 0);
    // R9 A=2 B=2 SUB
    step("R9", 0, 4'b0100, 4'b0110, 0, 0, 32'd2, 0);
    for (int o = 0; o < 8; o++) step("R9", 0, 4'b0010, 4'b0000, 0, o, 0, 0);
    // R8 wrap at zero and at top
    step("R8", 0, 4'b0100, 4'b0010, 0, 0, 32'd0, 0);
    step("R8", 0, 4'b0010, 4'b0000, 0, 3, 0, 0);
    step("R8", 0, 4'b0010, 4'b0000, 0, 5, 0, 0);
    step("R8", 0, 4'b0100, 4'b0010, 0, 0, 32'hFFFF_FFFC, 0);
    step("R8", 0, 4'b0100, 4'b0100, 0, 0, 32'd4, 0);
    for (int o = 2; o < 8; o++) step("R8", 0, 4'b0010, 4'b0000, 0, o, 0, 0);
    // R4 ALU result into MA via bus, hold afterwards
    step("R4", 0, 4'b0010, 4'b1000, 0, 4, 0, 0);
    step("R4", 0, 4'b0100, 4'b0000, 0, 0, 32'h5555_AAAA, 0);
    step("R4", 0, 4'b1000, 4'b0000, 0, 0, 0, 32'h0F0F_0F0F);
    // R2 idle bus, and loading the idle value
    step("R2", 0, 4'b0000, 4'b1000, 0, 0, 32'h1, 32'h2);
    step("R2", 0, 4'b0000, 4'b0000, 0, 0, 0, 0);
    // R3 every conflicting combination, no loads
    for (int e = 0; e < 16; e++) step("R3", 0, 4'(e), 4'b0000, 0, 0, 32'h3, 32'h7);
    // R5 all four registers in one cycle
    step("R5", 0, 4'b0100, 4'b1111, 0, 0, 32'hC0DE_0042, 0);
    step("R5", 0, 4'b0010, 4'b0000, 0, 0, 0, 0);
    step("R5", 0, 4'b0010, 4'b0000, 0, 1, 0, 0);
    step("R5", 0, 4'b0000, 4'b0000, 0, 0, 0, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule